// File: doc/BRIEF.md
# Iterative Truncating Signed Divider

This unit computes the 32-bit two's-complement quotient of a signed dividend and a signed divisor over many cycles. The caller raises `start_i` with both operands while the unit is idle. The unit then converts both operands to unsigned magnitudes and runs a radix-2 restoring loop that produces one quotient bit per clock. After the loop it applies the sign, so the result is rounded toward zero. The quotient is reported with a single-cycle `done_o` pulse and then stays on `quot_o` until a later result replaces it.

The unit has two corner cases, and neither raises a flag. A zero divisor is detected when the operands are accepted, and the unit completes at once with a quotient of zero. The most negative value divided by minus one wraps to the most negative value, because the result keeps only the low 32 bits of the exact quotient. The unit has no status or condition outputs.

Top module: `trunc_div_unit`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `busy_o` and `done_o` are 0 and `quot_o` is 0. Asserting reset while a division is running abandons that division.
- R2: For a non-zero divisor, `quot_o` is the exact quotient truncated toward zero, for all four sign combinations (for example -7 / 2 = -3 and -7 / -2 = 3). The result is negative only when exactly one operand is negative.
- R3: A zero divisor gives `quot_o` = 0 with `done_o` high in the cycle right after the accepting edge. `busy_o` never rises for such a request.
- R4: 0x80000000 divided by 0xFFFFFFFF gives 0x80000000, and no other output reports the overflow.
- R5: When the magnitude of the dividend is smaller than that of the divisor, the quotient is 0, whatever the signs.
- R6: `done_o` is high for one cycle per completed division. `quot_o` changes only on the edge that raises `done_o`, and holds its value at all other times.
- R7: A `start_i` presented while `busy_o` is high is ignored. The running division completes with its own operands and its normal latency.
- R8: For a non-zero divisor, `busy_o` is high for exactly W cycles after the accepting edge, with W = 32. `done_o` rises W cycles after that edge and is never high while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a division; accepted only while idle |
| dividend_i | input | 32 | Signed dividend, sampled on the accepting edge |
| divisor_i | input | 32 | Signed divisor, sampled on the accepting edge |
| busy_o | output | 1 | Iteration loop running |
| done_o | output | 1 | One-cycle pulse marking a new quotient |
| quot_o | output | 32 | Signed quotient, held until the next result |

## Verification
Most internal faults do not show up until the end of a division. A wrong partial remainder, a dropped quotient bit or a miscounted iteration stays hidden until the final edge. At that edge it appears as a wrong `quot_o` value, or as `done_o` arriving earlier or later than the fixed W-cycle mark. A wrong captured sign shows up only in the sign bit of a non-zero quotient. Both the truncation direction and the wrap case are therefore checked against exact expected values at every completion, together with the cycle count.

// File: rtl/trunc_div_pkg.sv
package trunc_div_pkg;

  typedef enum logic {
    DV_IDLE = 1'b0,
    DV_LOOP = 1'b1
  } dv_state_e;

  localparam int unsigned DV_NUM_OPS = 2;

endpackage

// File: rtl/trunc_div_abs.sv
module trunc_div_abs #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);

  always_comb begin
    neg_o = val_i[W-1];
    if (neg_o) begin
      mag_o = (~val_i) + {{(W-1){1'b0}}, 1'b1};
    end else begin
      mag_o = val_i;
    end
  end

endmodule

// File: rtl/trunc_div_core.sv
module trunc_div_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         run_i,
  input  logic [W-1:0] nmag_i,
  input  logic [W-1:0] dmag_i,
  output logic         last_o,
  output logic [W-1:0] qmag_nxt_o
);

  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  dsr_q, dsr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          reg_en;

  logic [W:0]    shifted;
  logic          fits;
  logic [W-1:0]  rem_step;
  logic [W-1:0]  quo_step;

  // one restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    shifted  = {rem_q, quo_q[W-1]};
    fits     = (shifted >= {1'b0, dsr_q});
    rem_step = fits ? (shifted[W-1:0] - dsr_q) : shifted[W-1:0];
    quo_step = {quo_q[W-2:0], fits};
  end

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dsr_d  = dsr_q;
    cnt_d  = cnt_q;
    reg_en = 1'b0;
    if (load_i) begin
      reg_en = 1'b1;
      rem_d  = '0;
      quo_d  = nmag_i;
      dsr_d  = dmag_i;
      cnt_d  = '0;
    end else if (run_i) begin
      reg_en = 1'b1;
      rem_d  = rem_step;
      quo_d  = quo_step;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
    end else if (reg_en) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dsr_q <= dsr_d;
      cnt_q <= cnt_d;
    end
  end

  assign last_o     = run_i && (cnt_q == LAST_CNT);
  assign qmag_nxt_o = quo_step;

endmodule

// File: rtl/trunc_div_sign.sv
module trunc_div_sign #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] mag_i,
  input  logic         neg_i,
  output logic [W-1:0] val_o
);

  always_comb begin
    if (neg_i) begin
      val_o = (~mag_i) + {{(W-1){1'b0}}, 1'b1};
    end else begin
      val_o = mag_i;
    end
  end

endmodule

// File: rtl/trunc_div_unit.sv
module trunc_div_unit
  import trunc_div_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);

  dv_state_e    state_q, state_d;
  logic         sign_q, sign_d;
  logic [W-1:0] quot_q, quot_d;
  logic         done_q, done_d;
  logic         quot_en;
  logic         sign_en;

  logic [W-1:0] op_raw [DV_NUM_OPS];
  logic [W-1:0] op_mag [DV_NUM_OPS];
  logic         op_neg [DV_NUM_OPS];

  logic         accept;
  logic         dsr_zero;
  logic         core_load;
  logic         core_run;
  logic         core_last;
  logic [W-1:0] qmag_nxt;
  logic [W-1:0] q_signed;

  assign op_raw[0] = dividend_i;
  assign op_raw[1] = divisor_i;

  for (genvar g = 0; g < DV_NUM_OPS; g++) begin : g_mag
    trunc_div_abs #(.W(W)) u_abs (
      .val_i (op_raw[g]),
      .mag_o (op_mag[g]),
      .neg_o (op_neg[g])
    );
  end

  assign accept    = start_i && (state_q == DV_IDLE);
  assign dsr_zero  = (divisor_i == '0);
  assign core_load = accept && !dsr_zero;
  assign core_run  = (state_q == DV_LOOP);

  trunc_div_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (core_load),
    .run_i      (core_run),
    .nmag_i     (op_mag[0]),
    .dmag_i     (op_mag[1]),
    .last_o     (core_last),
    .qmag_nxt_o (qmag_nxt)
  );

  trunc_div_sign #(.W(W)) u_sign (
    .mag_i (qmag_nxt),
    .neg_i (sign_q),
    .val_o (q_signed)
  );

  always_comb begin
    state_d = state_q;
    sign_d  = sign_q;
    sign_en = 1'b0;
    quot_d  = quot_q;
    quot_en = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      DV_IDLE: begin
        if (accept) begin
          if (dsr_zero) begin
            quot_en = 1'b1;
            quot_d  = '0;
            done_d  = 1'b1;
          end else begin
            sign_en = 1'b1;
            sign_d  = op_neg[0] ^ op_neg[1];
            state_d = DV_LOOP;
          end
        end
      end
      DV_LOOP: begin
        if (core_last) begin
          quot_en = 1'b1;
          quot_d  = q_signed;
          done_d  = 1'b1;
          state_d = DV_IDLE;
        end
      end
      default: state_d = DV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DV_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
    end else if (sign_en) begin
      sign_q <= sign_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
    end else if (quot_en) begin
      quot_q <= quot_d;
    end
  end

  assign busy_o = (state_q == DV_LOOP);
  assign done_o = done_q;
  assign quot_o = quot_q;

endmodule

// File: rtl/trunc_div_chk.sv
module trunc_div_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quot_o
);

  localparam int unsigned LW = $clog2(W + 2);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic          acc;
  logic          trk_q;
  logic [LW-1:0] lat_q;
  logic          ovf_q;
  logic          eneg_q;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q  <= 1'b0;
      lat_q  <= '0;
      ovf_q  <= 1'b0;
      eneg_q <= 1'b0;
    end else if (acc) begin
      trk_q  <= (divisor_i != '0);
      lat_q  <= LW'(1);
      ovf_q  <= (dividend_i == MOST_NEG) && (divisor_i == '1);
      eneg_q <= dividend_i[W-1] ^ divisor_i[W-1];
    end else if (done_o) begin
      trk_q <= 1'b0;
    end else if (trk_q) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  a_r3_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && divisor_i == '0) |=> (done_o && quot_o == '0 && !busy_o));

  a_r8_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q && lat_q == LW'(W)) |=> done_o);

  a_r6_quot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(quot_o));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q && ovf_q && done_o) |-> (quot_o == MOST_NEG));

  a_r2_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q && !ovf_q && done_o && quot_o != '0) |-> (quot_o[W-1] == eneg_q));

endmodule

bind trunc_div_unit trunc_div_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .quot_o     (quot_o)
);

// File: tb/trunc_div_unit_bench.sv
module trunc_div_unit_bench;

  localparam int W    = 32;
  localparam int NVEC = 15;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  dvd;
  logic [W-1:0]  dvs;
  logic          busy;
  logic          done;
  logic [W-1:0]  quot;

  int checks;
  int errors;

  trunc_div_unit #(.W(W)) u_trunc_div_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .dividend_i (dvd),
    .divisor_i  (dvs),
    .busy_o     (busy),
    .done_o     (done),
    .quot_o     (quot)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {dividend, divisor, expected quotient}
  localparam logic [95:0] VEC [NVEC] = '{
    {32'h0000_0007, 32'h0000_0002, 32'h0000_0003},  // R2 + / +
    {32'hFFFF_FFF9, 32'h0000_0002, 32'hFFFF_FFFD},  // R2 - / +
    {32'h0000_0007, 32'hFFFF_FFFE, 32'hFFFF_FFFD},  // R2 + / -
    {32'hFFFF_FFF9, 32'hFFFF_FFFE, 32'h0000_0003},  // R2 - / -
    {32'h0000_0064, 32'h0000_0007, 32'h0000_000E},  // R2
    {32'hFFF0_BDC0, 32'h0000_0003, 32'hFFFA_E9EB},  // R2
    {32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000},  // R4 wrap
    {32'h8000_0000, 32'h0000_0001, 32'h8000_0000},  // R2
    {32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0001},  // R2
    {32'h8000_0000, 32'h8000_0000, 32'h0000_0001},  // R2
    {32'h0000_0005, 32'h0000_0000, 32'h0000_0000},  // R3 zero divisor
    {32'h0000_0003, 32'h0000_000A, 32'h0000_0000},  // R5
    {32'hFFFF_FFFD, 32'h0000_000A, 32'h0000_0000},  // R5
    {32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000},  // R5
    {32'h0000_0000, 32'hFFFF_FFFB, 32'h0000_0000}   // R5
  };

  function automatic logic [W-1:0] ref_div(logic [W-1:0] a, logic [W-1:0] b);
    longint sa;
    longint sb;
    longint sq;
    if (b == '0) return '0;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sq = sa / sb;
    return sq[W-1:0];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] q, output int lat, output logic busy1);
    @(negedge clk);
    start = 1'b1;
    dvd   = a;
    dvs   = b;
    @(negedge clk);
    start = 1'b0;
    busy1 = busy;
    lat   = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    q = quot;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] q;
    logic [W-1:0] held;
    int           lat;
    logic         b1;

    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    start  = 1'b0;
    dvd    = '0;
    dvs    = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", W'(busy), '0);
    chk("R1 done in reset", W'(done), '0);
    chk("R1 quot in reset", quot, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", W'(busy), '0);
    chk("R1 quot after release", quot, '0);

    // table walk: value and latency per vector
    for (int i = 0; i < NVEC; i++) begin
      logic [W-1:0] va, vb, ve;
      {va, vb, ve} = VEC[i];
      run_div(va, vb, q, lat, b1);
      chk($sformatf("R2/R4/R5 vec %0d value", i), q, ve);
      if (vb == '0) begin
        chk($sformatf("R3 vec %0d latency", i), W'(lat), '0);
        chk($sformatf("R3 vec %0d busy", i), W'(b1), '0);
      end else begin
        chk($sformatf("R8 vec %0d latency", i), W'(lat), W'(W));
        chk($sformatf("R8 vec %0d busy", i), W'(b1), 'd1);
      end
    end

    // R6: done is a pulse, quotient held afterwards
    run_div(32'hFFFF_FF9C, 32'h0000_0007, q, lat, b1);
    held = q;
    chk("R2 -100/7", q, 32'hFFFF_FFF2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 done low after pulse", W'(done), '0);
      chk("R6 quot held", quot, held);
    end

    // R7: start while busy is ignored
    @(negedge clk);
    start = 1'b1;
    dvd   = 32'd100;
    dvs   = 32'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    dvd   = 32'd1;
    dvs   = 32'd0;
    @(negedge clk);
    start = 1'b0;
    chk("R7 still busy", W'(busy), 'd1);
    chk("R6 quot held while busy", quot, held);
    lat = 5;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R7 latency unchanged", W'(lat), W'(W));
    chk("R7 own operands", quot, 32'd14);

    // R1: reset during a division
    run_div(32'd9, 32'd4, q, lat, b1);
    @(negedge clk);
    start = 1'b1;
    dvd   = 32'd50;
    dvs   = 32'd5;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run busy", W'(busy), '0);
    chk("R1 mid-run quot", quot, '0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 no late done", W'(done), '0);

    // R2/R5 random against model
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 3 == 0) rb = W'($signed(rb) >>> 20);
      if (i % 5 == 0) ra = W'($signed(ra) >>> 24);
      if (i % 11 == 0) rb = '0;
      run_div(ra, rb, q, lat, b1);
      chk($sformatf("R2 random %h/%h", ra, rb), q, ref_div(ra, rb));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule